// File: doc/BRIEF.md
# Oversampling Digital Clock Recovery Unit

This block turns a raw serial receive line into clean data and a bit-rate timing strobe. It works from a single oversampling tick. All of its logic runs on the system clock and advances only on that tick. A 3-sample majority filter cleans the data. The filtered data then passes through a one-tick delay stage. A clock extractor compares the filtered data with the delayed data to find transitions. It keeps a modulo-N phase counter aligned to them, and from that counter it issues a mid-bit sample strobe and an end-of-bit clock strobe. The rate field selects N.

The tick can come from two places: a baud tick supplied from outside, or the rising edges of the external receive clock line. In the filter modes the extractor is held cleared. The external clock is then majority-filtered on the baud tick, and its rising edges become the clock strobe. When the extractor runs from the baud tick, the block also drives a recovered square wave toward the external clock pin and raises an output enable for it.

Top module: `dpll_rx_recover`

## Requirements
- R1: The operating tick is `brg_tick` when `mode_sel` is 0, 2 or 3, and is a rising edge of `ext_clk_raw` (high now, low in the previous clock) when `mode_sel` is 1. In a clock without a tick, no filter, delay or counter state changes, and both strobes are 0 in the following clock.
- R2: On each tick, the data filter output becomes the majority of the two previous raw samples and the current one. A raw pulse that lasts one tick never reaches `rx_data`.
- R3: `rx_data` is the filtered data delayed by exactly one tick.
- R4: `rate_sel` sets the oversampling ratio N: 00 gives 8, 01 gives 16, 10 gives 32, and the reserved code 11 gives 16. While the data line stays constant after lock, clock strobes are N ticks apart.
- R5: After reset the extractor is unlocked and gives no strobes. It locks on the first tick at which the filtered data differs from the delayed data, and it sets its count to 1 on that tick.
- R6: While locked, each tick advances the count modulo N, except where R7 applies. The sample strobe pulses one clock after a tick that takes the count to N/2. The clock strobe pulses one clock after a tick at which the count wraps to a lower value.
- R7: On a locked tick with a transition, the count is adjusted by at most one: a count of 0 advances normally, a count of 1 to N/2-1 holds, and a count of N/2 to N-1 advances by 2 modulo N.
- R8: With `mode_sel` 2 or 3, the extractor is cleared and the sample strobe stays 0. The external clock is majority-filtered on each tick, with an idle level of 0, and the clock strobe pulses one clock after a tick on which that filtered clock rises.
- R9: `ext_clk_oe` is 1 only in mode 0. In mode 0, `ext_clk_out` is 1 exactly when the extractor is locked and its count is at least N/2. In every other mode it is 0.
- R10: A synchronous active-high reset sets `rx_data` and the data filter history to 1, the external-clock filter to 0, and the count to 0, leaves the extractor unlocked, and sets both strobes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| brg_tick | input | 1 | Baud-rate oversampling tick, one clock wide |
| rx_raw | input | 1 | Raw receive data, synchronous to clk |
| ext_clk_raw | input | 1 | Raw external receive clock level, synchronous to clk |
| rate_sel | input | 2 | Oversampling ratio code |
| mode_sel | input | 2 | 0 extract on baud tick, 1 extract on external clock, 2/3 filter external clock |
| rx_data | output | 1 | Filtered and delayed receive data |
| rx_clk_stb | output | 1 | Recovered bit-clock strobe |
| rx_sample_stb | output | 1 | Mid-bit sample strobe (extraction modes) |
| ext_clk_oe | output | 1 | Output enable for driving the recovered clock on the clock pin |
| ext_clk_out | output | 1 | Recovered clock level for the clock pin |

## Verification
The bench feeds data that runs slightly slow and slightly fast. This forces repeated hold and double-step corrections, and a design that got the window edges of the correction wrong would slip strobes or fire the clock strobe twice in a bit. Single-tick glitches on the data and on the external clock are injected, and a filter with too short a window would pass them to `rx_data` or produce extra clock strobes. An idle line after reset must produce no strobe at all, which catches an extractor that free-runs before lock. The strobe period is measured for every rate code, including the reserved one, and a wrong ratio decode or a wrong wrap value shows up as a wrong period.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

    localparam int MAX_RATIO = 32;
    localparam int BASE_RATIO = 8;
    localparam int CNT_W = $clog2(MAX_RATIO);
    localparam int LANES = 2;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [CNT_W:0]   ratio_t;

    typedef enum logic [1:0] {
        MODE_EXTR_BRG = 2'd0,
        MODE_EXTR_EXT = 2'd1,
        MODE_FILT     = 2'd2,
        MODE_FILT_ALT = 2'd3
    } mode_e;

    typedef struct packed {
        logic clk_stb;
        logic smp_stb;
    } strobe_t;

    function automatic ratio_t ratio_of(input logic [1:0] code);
        case (code)
            2'b00:   return ratio_t'(BASE_RATIO);
            2'b01:   return ratio_t'(BASE_RATIO * 2);
            2'b10:   return ratio_t'(BASE_RATIO * 4);
            default: return ratio_t'(BASE_RATIO * 2);
        endcase
    endfunction

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic is_filter_mode(input mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/dpll_tick_sel.sv
module dpll_tick_sel
    import dpll_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  brg_tick,
    input  logic  ext_clk_raw,
    input  mode_e mode,
    output logic  tick
);
    logic ext_prev;

    always_ff @(posedge clk) begin
        if (rst) ext_prev <= 1'b0;
        else     ext_prev <= ext_clk_raw;
    end

    always_comb begin
        if (mode == MODE_EXTR_EXT) tick = ext_clk_raw & ~ext_prev;
        else                       tick = brg_tick;
    end
endmodule

// File: rtl/dpll_maj_filter.sv
module dpll_maj_filter #(
    parameter logic IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic din,
    output logic dout,
    output logic nxt
);
    logic [1:0] hist;

    always_comb nxt = dpll_pkg::maj3(hist[1], hist[0], din);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= {2{IDLE}};
            dout <= IDLE;
        end else if (tick) begin
            hist <= {hist[0], din};
            dout <= nxt;
        end
    end
endmodule

// File: rtl/dpll_extractor.sv
module dpll_extractor
    import dpll_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    filt_mode,
    input  ratio_t  ratio,
    input  logic    d_filt,
    input  logic    ext_rise,
    output logic    d_dly,
    output cnt_t    cnt_q,
    output logic    locked_q,
    output strobe_t stb_q
);
    cnt_t lim_m1;
    cnt_t half;
    cnt_t cnt_adv1;
    cnt_t cnt_adv2;
    cnt_t cnt_nxt;
    logic edge_seen;
    logic wrap;
    logic reach_half;

    always_comb begin
        lim_m1    = cnt_t'(ratio - ratio_t'(1));
        half      = cnt_t'(ratio >> 1);
        edge_seen = d_filt ^ d_dly;

        if (cnt_q >= lim_m1) cnt_adv1 = '0;
        else                 cnt_adv1 = cnt_q + cnt_t'(1);

        if (cnt_q >= lim_m1)                     cnt_adv2 = cnt_t'(1);
        else if (cnt_q == lim_m1 - cnt_t'(1))    cnt_adv2 = '0;
        else                                     cnt_adv2 = cnt_q + cnt_t'(2);

        if (!edge_seen || cnt_q == '0) cnt_nxt = cnt_adv1;
        else if (cnt_q < half)         cnt_nxt = cnt_q;
        else                           cnt_nxt = cnt_adv2;

        wrap       = cnt_nxt < cnt_q;
        reach_half = (cnt_nxt == half) && (cnt_q != half);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_dly    <= 1'b1;
            cnt_q    <= '0;
            locked_q <= 1'b0;
            stb_q    <= '0;
        end else begin
            stb_q <= '0;
            if (tick) begin
                d_dly <= d_filt;
                if (filt_mode) begin
                    locked_q      <= 1'b0;
                    cnt_q         <= '0;
                    stb_q.clk_stb <= ext_rise;
                end else if (!locked_q) begin
                    if (edge_seen) begin
                        locked_q <= 1'b1;
                        cnt_q    <= cnt_t'(1);
                    end
                end else begin
                    cnt_q         <= cnt_nxt;
                    stb_q.clk_stb <= wrap;
                    stb_q.smp_stb <= reach_half;
                end
            end
        end
    end
endmodule

// File: rtl/dpll_rx_recover.sv
module dpll_rx_recover
    import dpll_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       brg_tick,
    input  logic       rx_raw,
    input  logic       ext_clk_raw,
    input  logic [1:0] rate_sel,
    input  logic [1:0] mode_sel,
    output logic       rx_data,
    output logic       rx_clk_stb,
    output logic       rx_sample_stb,
    output logic       ext_clk_oe,
    output logic       ext_clk_out
);
    localparam logic [LANES-1:0] LANE_IDLE = 2'b01;

    mode_e            mode;
    logic             tick;
    logic [LANES-1:0] lane_in;
    logic [LANES-1:0] lane_out;
    logic [LANES-1:0] lane_nxt;
    logic             ext_rise;
    ratio_t           ratio;
    cnt_t             half;
    cnt_t             cnt_q;
    logic             locked_q;
    logic             d_dly;
    strobe_t          stb_q;

    always_comb begin
        mode     = mode_e'(mode_sel);
        ratio    = ratio_of(rate_sel);
        half     = cnt_t'(ratio >> 1);
        lane_in  = {ext_clk_raw, rx_raw};
        ext_rise = tick & lane_nxt[1] & ~lane_out[1];
    end

    dpll_tick_sel u_tick (
        .clk         (clk),
        .rst         (rst),
        .brg_tick    (brg_tick),
        .ext_clk_raw (ext_clk_raw),
        .mode        (mode),
        .tick        (tick)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dpll_maj_filter #(.IDLE(LANE_IDLE[g])) u_filt (
            .clk  (clk),
            .rst  (rst),
            .tick (tick),
            .din  (lane_in[g]),
            .dout (lane_out[g]),
            .nxt  (lane_nxt[g])
        );
    end

    dpll_extractor u_extr (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .filt_mode (is_filter_mode(mode)),
        .ratio     (ratio),
        .d_filt    (lane_out[0]),
        .ext_rise  (ext_rise),
        .d_dly     (d_dly),
        .cnt_q     (cnt_q),
        .locked_q  (locked_q),
        .stb_q     (stb_q)
    );

    always_comb begin
        rx_data       = d_dly;
        rx_clk_stb    = stb_q.clk_stb;
        rx_sample_stb = stb_q.smp_stb;
        ext_clk_oe    = (mode == MODE_EXTR_BRG);
        ext_clk_out   = ext_clk_oe && locked_q && (cnt_q >= half);
    end
endmodule

// File: rtl/dpll_rx_recover_chk.sv
module dpll_rx_recover_chk
    import dpll_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       brg_tick,
    input logic [1:0] rate_sel,
    input logic [1:0] mode_sel,
    input logic       rx_data,
    input logic       rx_clk_stb,
    input logic       rx_sample_stb,
    input logic       ext_clk_oe,
    input logic       ext_clk_out,
    input logic       locked_q,
    input cnt_t       cnt_q
);
    assert_no_tick_no_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_sel != 2'd1) && $past(!brg_tick)) |-> (!rx_clk_stb && !rx_sample_stb));

    assert_data_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_sel != 2'd1 && !brg_tick) |=> $stable(rx_data));

    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == $past(rate_sel) && ratio_t'($past(cnt_q)) < ratio_of(rate_sel))
        |-> ratio_t'(cnt_q) < ratio_of(rate_sel));

    assert_idle_until_lock_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(!locked_q) && $past(!mode_sel[1])) |-> (!rx_clk_stb && !rx_sample_stb));

    assert_strobes_apart_R6: assert property (@(posedge clk) disable iff (rst)
        !(rx_clk_stb && rx_sample_stb));

    assert_filter_no_sample_R8: assert property (@(posedge clk) disable iff (rst)
        $past(mode_sel[1]) |-> !rx_sample_stb);

    assert_pin_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !ext_clk_oe |-> !ext_clk_out);
endmodule

bind dpll_rx_recover dpll_rx_recover_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .brg_tick      (brg_tick),
    .rate_sel      (rate_sel),
    .mode_sel      (mode_sel),
    .rx_data       (rx_data),
    .rx_clk_stb    (rx_clk_stb),
    .rx_sample_stb (rx_sample_stb),
    .ext_clk_oe    (ext_clk_oe),
    .ext_clk_out   (ext_clk_out),
    .locked_q      (locked_q),
    .cnt_q         (cnt_q)
);

// File: tb/dpll_rx_recover_test.sv
`timescale 1ns/100ps
module dpll_rx_recover_test;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst = 1'b1;
    logic       brg_tick = 1'b0;
    logic       rx_raw = 1'b1;
    logic       ext_clk_raw = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic [1:0] mode_sel = 2'd0;
    logic       rx_data, rx_clk_stb, rx_sample_stb, ext_clk_oe, ext_clk_out;

    dpll_rx_recover uut (
        .clk(clk), .rst(rst), .brg_tick(brg_tick), .rx_raw(rx_raw),
        .ext_clk_raw(ext_clk_raw), .rate_sel(rate_sel), .mode_sel(mode_sel),
        .rx_data(rx_data), .rx_clk_stb(rx_clk_stb), .rx_sample_stb(rx_sample_stb),
        .ext_clk_oe(ext_clk_oe), .ext_clk_out(ext_clk_out)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    // behavioural reference state
    bit dq[$];
    bit eq[$];
    bit m_df, m_dd, m_ef, m_ep, m_lock, m_cs, m_ss;
    int m_cnt;

    function automatic int ratio_for(input int code);
        case (code)
            0: return 8;
            1: return 16;
            2: return 32;
            default: return 16;
        endcase
    endfunction

    task automatic model_reset();
        dq = {1'b1, 1'b1};
        eq = {1'b0, 1'b0};
        m_df = 1; m_dd = 1; m_ef = 0; m_ep = 0;
        m_lock = 0; m_cnt = 0; m_cs = 0; m_ss = 0;
    endtask

    task automatic model_step();
        bit tk, nf, ne, of, od, oe;
        int n, nx, ones;
        if (rst) begin
            model_reset();
            return;
        end
        tk = (mode_sel == 2'd1) ? (ext_clk_raw && !m_ep) : brg_tick;   // R1
        m_ep = ext_clk_raw;
        m_cs = 0; m_ss = 0;
        if (!tk) return;
        of = m_df; od = m_dd; oe = m_ef;
        ones = int'(dq[0]) + int'(dq[1]) + int'(rx_raw);
        nf = (ones >= 2);
        void'(dq.pop_front()); dq.push_back(rx_raw);
        ones = int'(eq[0]) + int'(eq[1]) + int'(ext_clk_raw);
        ne = (ones >= 2);
        void'(eq.pop_front()); eq.push_back(ext_clk_raw);
        n = ratio_for(int'(rate_sel));
        if (mode_sel >= 2) begin
            m_lock = 0; m_cnt = 0;
            m_cs = ne && !oe;
        end else if (!m_lock) begin
            if (of != od) begin m_lock = 1; m_cnt = 1; end
        end else begin
            if (of == od || m_cnt == 0) nx = (m_cnt + 1) % n;
            else if (m_cnt < n / 2)     nx = m_cnt;
            else                        nx = (m_cnt + 2) % n;
            m_cs = (nx < m_cnt);
            m_ss = (nx == n / 2) && (m_cnt != n / 2);
            m_cnt = nx;
        end
        m_dd = of;
        m_df = nf;
        m_ef = ne;
    endtask

    task automatic check_bit(input string tag, input string nm, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at cycle %0d", tag, nm, act, exp, cyc);
        end
    endtask

    task automatic check_int(input string tag, input string nm, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
        end
    endtask

    task automatic step(input bit bt, input bit r, input bit e);
        bit x_out;
        brg_tick = bt; rx_raw = r; ext_clk_raw = e;
        @(posedge clk);
        @(negedge clk);
        cyc++;
        model_step();
        x_out = (mode_sel == 2'd0) && m_lock && (m_cnt >= ratio_for(int'(rate_sel)) / 2);
        check_bit("R2,R3", "rx_data", rx_data, m_dd);
        check_bit("R6,R8", "rx_sample_stb", rx_sample_stb, m_ss);
        check_bit("R6,R7,R8", "rx_clk_stb", rx_clk_stb, m_cs);
        check_bit("R9", "ext_clk_oe", ext_clk_oe, mode_sel == 2'd0);
        check_bit("R9", "ext_clk_out", ext_clk_out, x_out);
    endtask

    task automatic do_reset(input int rate, input int mode);
        rate_sel = rate[1:0]; mode_sel = mode[1:0];
        rst = 1;
        step(0, 1, 0);
        step(0, 1, 0);
        rst = 0;
    endtask

    task automatic run_stream(input int rate, input int mode, input int nbits,
                              input int bit_len, input int glitch_every, input int cpt);
        logic [7:0] lfsr;
        bit level;
        do_reset(rate, mode);
        lfsr = 8'hA5 ^ 8'(rate * 7 + mode);
        for (int b = 0; b < nbits; b++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            level = lfsr[0];
            for (int t = 0; t < bit_len; t++) begin
                bit r, g, ec;
                g = (glitch_every > 0) && ((b % glitch_every) == 0) && (t == bit_len / 2);
                r = level ^ g;
                for (int c = 0; c < cpt; c++) begin
                    bit bt;
                    case (mode)
                        1: begin bt = (c == 1); ec = (c < cpt / 2); end
                        2, 3: begin bt = (c == 0); ec = ((b % 2) == 1) ^ g; end
                        default: begin bt = (c == 0); ec = 1'b0; end
                    endcase
                    step(bt, r, ec);
                end
            end
        end
    endtask

    // R4: spacing of clock strobes on a constant line after one edge
    task automatic measure_period(input int rate);
        int s[3];
        int k;
        do_reset(rate, 0);
        for (int i = 0; i < 6; i++) step(i % 2 == 0, 1, 0);
        k = 0;
        for (int i = 0; i < 600 && k < 3; i++) begin
            step(i % 2 == 0, 0, 0);
            if (rx_clk_stb) begin s[k] = cyc; k++; end
        end
        check_int("R4", "strobes seen", k, 3);
        check_int("R4", "strobe period clocks", s[2] - s[1], 2 * ratio_for(rate));
    endtask

    // R5: idle line gives no strobes
    task automatic idle_line();
        int seen = 0;
        do_reset(1, 0);
        for (int i = 0; i < 200; i++) begin
            step(i % 2 == 0, 1, 0);
            if (rx_clk_stb || rx_sample_stb) seen++;
        end
        check_int("R5", "strobes before first edge", seen, 0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        step(0, 1, 0);
        // R10: reset state
        check_bit("R10", "reset rx_data", rx_data, 1'b1);
        check_bit("R10", "reset rx_clk_stb", rx_clk_stb, 1'b0);
        check_bit("R10", "reset rx_sample_stb", rx_sample_stb, 1'b0);
        check_bit("R10", "reset ext_clk_out", ext_clk_out, 1'b0);
        idle_line();
        run_stream(0, 0, 40, 8, 0, 2);    // clean x8
        run_stream(1, 0, 40, 16, 3, 2);   // x16 with glitches (R2)
        run_stream(2, 0, 24, 32, 4, 2);   // x32
        run_stream(3, 0, 30, 16, 0, 2);   // reserved code (R4)
        run_stream(1, 0, 40, 17, 0, 2);   // slow data, hold corrections (R7)
        run_stream(1, 0, 40, 15, 0, 2);   // fast data, advance corrections (R7)
        run_stream(0, 0, 40, 9, 5, 3);    // slow x8, sparse ticks
        run_stream(0, 1, 40, 8, 0, 4);    // tick from external clock (R1)
        run_stream(1, 1, 20, 15, 3, 4);
        run_stream(0, 2, 40, 8, 3, 2);    // filter mode (R8)
        run_stream(1, 3, 20, 16, 2, 2);   // alternate filter code (R8)
        for (int r = 0; r < 4; r++) measure_period(r);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule